// File: doc/BRIEF.md
# Programmable Trigger Delay Unit

This block turns a single trigger event into a set of delayed pre-trigger pulses. It is typically used to schedule converter sampling at fixed offsets after a timing event. The trigger can come from one of several external lines, each passed through a two-flop synchronizer and an edge detector, or from a software strobe. An accepted trigger resets a counter to zero and starts it. Each channel compares the running count against its own delay value and emits a one-cycle pulse on a match. A channel can instead be set to bypass, which fires it one cycle after the trigger regardless of its delay. Channels are organised in groups, and each group drives one combined trigger output.

The counter is driven by a three-state machine. IDLE means stopped. On an accepted trigger the machine moves IDLE->RUN with the count cleared. In RUN it advances by one per cycle. When the count reaches the modulus, one-shot mode takes RUN->IDLE and holds the count at the modulus, while continuous mode wraps the count to zero and stays in RUN. A new trigger in RUN restarts the count at zero. A high debug-halt input moves RUN->HOLD, where the count is frozen and triggers are ignored. When the input falls, HOLD->RUN resumes at the next count value. Clearing the enable sends any state to IDLE with the count at zero. The count is brought out on a port so the sequencing can be observed.

Top module: `tdu_top`

## Requirements
- R1: While `enable` is low, the counter is held at zero, and no non-bypassed channel pulses.
- R2: With `trig_sel` equal to N_EXT (4), a one-cycle `sw_trig` strobe is accepted. With `trig_sel` equal to i < N_EXT, a rising edge on `ext_trig[i]` is accepted three clock edges after it is applied (two synchronizer flops plus the edge register). An accepted trigger sets the count to 0 and starts counting. Edges on unselected lines are ignored.
- R3: An external line held high produces exactly one trigger event.
- R4: An enabled, non-bypassed channel whose delay is d pulses `pre_trig` for exactly one cycle, in the cycle after the count equals d. For a software trigger sampled at edge E0, the pulse is visible after edge E(d+1).
- R5: In one-shot mode (`cont_mode` = 0), the count runs 0..modulus and then stops at the modulus. Each enabled channel pulses once per trigger event, and a delay above the modulus never pulses.
- R6: In continuous mode (`cont_mode` = 1), the count wraps to 0 after reaching the modulus. Each enabled channel then pulses every modulus+1 cycles.
- R7: An enabled channel with its bypass bit set pulses in the cycle right after an accepted trigger, ignoring its delay and the state of `enable`.
- R8: A channel whose `pre_en` bit is low never pulses.
- R9: `trig_out[g]` is the OR of `pre_trig[g*N_PRE +: N_PRE]`.
- R10: While `dbg_halt` is high, the count holds its value and triggers are ignored. After the fall of `dbg_halt`, the count continues with the next value.
- R11: A trigger that arrives while counting restarts the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| cont_mode | input | 1 | 1 = continuous, 0 = one-shot |
| dbg_halt | input | 1 | Debug pause of the counter |
| trig_sel | input | SEL_W (3) | Trigger source; N_EXT selects software |
| ext_trig | input | N_EXT (4) | Asynchronous external trigger lines |
| sw_trig | input | 1 | Software trigger strobe |
| modulus | input | CNT_W (16) | Terminal count |
| delay | input | N_GRP*N_PRE*CNT_W (128) | Per-channel delays, channel i at [i*CNT_W +: CNT_W] |
| pre_en | input | N_GRP*N_PRE (8) | Per-channel enable |
| pre_byp | input | N_GRP*N_PRE (8) | Per-channel bypass |
| pre_trig | output | N_GRP*N_PRE (8) | Pre-trigger pulses |
| trig_out | output | N_GRP (2) | Per-group combined trigger |
| count | output | CNT_W (16) | Current counter value |

## Verification
The assertions rely on the configuration inputs (modulus, delays, channel enables and bypass bits, mode and source select) being steady while a count is in progress. They also rely on external lines changing slowly compared with the clock, so that the synchronizer sees clean levels. The bench sets the configuration only while the block is disabled or idle, and holds each external line for many cycles. It drives the software strobe for a single cycle at a falling clock edge, and releases debug halt only at falling edges well inside a count.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tdu_state_e;
endpackage

// File: rtl/tdu_trig_sel.sv
module tdu_trig_sel #(
    parameter int N_EXT = 4,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_trig,
    input  logic             sw_trig,
    input  logic [SEL_W-1:0] trig_sel,
    output logic             trig_evt
);
    localparam logic [SEL_W-1:0] SW_CODE = SEL_W'(N_EXT);

    logic [N_EXT-1:0] meta_q;
    logic [N_EXT-1:0] sync_q;
    logic [N_EXT-1:0] last_q;
    logic [N_EXT-1:0] rise;
    logic [N_EXT-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= ext_trig;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;

    for (genvar i = 0; i < N_EXT; i++) begin : g_line
        assign hit[i] = rise[i] && (trig_sel == SEL_W'(i));
    end

    assign trig_evt = (|hit) || (sw_trig && (trig_sel == SW_CODE));
endmodule

// File: rtl/tdu_seq.sv
module tdu_seq
    import tdu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cont_mode,
    input  logic             dbg_halt,
    input  logic             trig_evt,
    input  logic [CNT_W-1:0] modulus,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             byp_go,
    output logic             trig_go
);
    tdu_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             at_end;

    assign byp_go  = trig_evt && !dbg_halt;
    assign trig_go = byp_go && enable;
    assign at_end  = (cnt_q >= modulus);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (!enable) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (trig_go) begin
                        st_n  = ST_RUN;
                        cnt_n = '0;
                    end
                end
                ST_RUN, ST_HOLD: begin
                    if (dbg_halt) begin
                        st_n = ST_HOLD;
                    end else if (trig_go) begin
                        st_n  = ST_RUN;
                        cnt_n = '0;
                    end else if (at_end) begin
                        st_n  = cont_mode ? ST_RUN : ST_IDLE;
                        cnt_n = cont_mode ? '0 : cnt_q;
                    end else begin
                        st_n  = ST_RUN;
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign count   = cnt_q;
    assign running = (st_q == ST_RUN);
endmodule

// File: rtl/tdu_chan.sv
module tdu_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             running,
    input  logic             byp_go,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] dly,
    input  logic             ch_en,
    input  logic             ch_byp,
    output logic             pre
);
    logic match;

    assign match = enable && running && (count == dly);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= 1'b0;
        end else begin
            pre <= ch_en && (ch_byp ? byp_go : match);
        end
    end
endmodule

// File: rtl/tdu_top.sv
module tdu_top #(
    parameter int N_EXT = 4,
    parameter int SEL_W = 3,
    parameter int CNT_W = 16,
    parameter int N_GRP = 2,
    parameter int N_PRE = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic                         cont_mode,
    input  logic                         dbg_halt,
    input  logic [SEL_W-1:0]             trig_sel,
    input  logic [N_EXT-1:0]             ext_trig,
    input  logic                         sw_trig,
    input  logic [CNT_W-1:0]             modulus,
    input  logic [N_GRP*N_PRE*CNT_W-1:0] delay,
    input  logic [N_GRP*N_PRE-1:0]       pre_en,
    input  logic [N_GRP*N_PRE-1:0]       pre_byp,
    output logic [N_GRP*N_PRE-1:0]       pre_trig,
    output logic [N_GRP-1:0]             trig_out,
    output logic [CNT_W-1:0]             count
);
    localparam int N_CH = N_GRP * N_PRE;

    logic trig_evt;
    logic running;
    logic byp_go;
    logic trig_go;

    tdu_trig_sel #(.N_EXT(N_EXT), .SEL_W(SEL_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_trig (ext_trig),
        .sw_trig  (sw_trig),
        .trig_sel (trig_sel),
        .trig_evt (trig_evt)
    );

    tdu_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cont_mode (cont_mode),
        .dbg_halt  (dbg_halt),
        .trig_evt  (trig_evt),
        .modulus   (modulus),
        .count     (count),
        .running   (running),
        .byp_go    (byp_go),
        .trig_go   (trig_go)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tdu_chan #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable),
            .running (running),
            .byp_go  (byp_go),
            .count   (count),
            .dly     (delay[c*CNT_W +: CNT_W]),
            .ch_en   (pre_en[c]),
            .ch_byp  (pre_byp[c]),
            .pre     (pre_trig[c])
        );
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign trig_out[g] = |pre_trig[g*N_PRE +: N_PRE];
    end
endmodule

// File: rtl/tdu_chk.sv
module tdu_chk #(
    parameter int N_EXT = 4,
    parameter int SEL_W = 3,
    parameter int CNT_W = 16,
    parameter int N_CH  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cont_mode,
    input logic             dbg_halt,
    input logic [SEL_W-1:0] trig_sel,
    input logic [CNT_W-1:0] modulus,
    input logic [N_CH-1:0]  pre_en,
    input logic [N_CH-1:0]  pre_byp,
    input logic [N_CH-1:0]  pre_trig,
    input logic [CNT_W-1:0] count,
    input logic             trig_evt,
    input logic             running,
    input logic             byp_go,
    input logic             trig_go
);
    // R1
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0) && ((pre_trig & ~$past(pre_byp)) == '0));

    // R11
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_go |=> (count == '0));

    // R3
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && (trig_sel < SEL_W'(N_EXT))) |=> (!trig_evt || (trig_sel != $past(trig_sel))));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cont_mode && !dbg_halt && !trig_go && (count == modulus))
            |=> (count == $past(count)));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cont_mode && running && !dbg_halt && !trig_go && (count == modulus))
            |=> (count == '0));

    // R7
    bypass_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_go |=> ((pre_trig & $past(pre_en & pre_byp)) == $past(pre_en & pre_byp)));

    // R8
    chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_trig & ~$past(pre_en)) == '0);

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && enable) |=> $stable(count));
endmodule

bind tdu_top tdu_chk #(
    .N_EXT (N_EXT),
    .SEL_W (SEL_W),
    .CNT_W (CNT_W),
    .N_CH  (N_GRP*N_PRE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cont_mode (cont_mode),
    .dbg_halt  (dbg_halt),
    .trig_sel  (trig_sel),
    .modulus   (modulus),
    .pre_en    (pre_en),
    .pre_byp   (pre_byp),
    .pre_trig  (pre_trig),
    .count     (count),
    .trig_evt  (trig_evt),
    .running   (running),
    .byp_go    (byp_go),
    .trig_go   (trig_go)
);

// File: tb/tdu_top_tb.sv
module tdu_top_tb;
    localparam int N_EXT = 4;
    localparam int SEL_W = 3;
    localparam int CNT_W = 16;
    localparam int N_GRP = 2;
    localparam int N_PRE = 4;
    localparam int N_CH  = N_GRP * N_PRE;
    localparam int M     = 12;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   enable;
    logic                   cont_mode;
    logic                   dbg_halt;
    logic [SEL_W-1:0]       trig_sel;
    logic [N_EXT-1:0]       ext_trig;
    logic                   sw_trig;
    logic [CNT_W-1:0]       modulus;
    logic [N_CH*CNT_W-1:0]  delay;
    logic [N_CH-1:0]        pre_en;
    logic [N_CH-1:0]        pre_byp;
    logic [N_CH-1:0]        pre_trig;
    logic [N_GRP-1:0]       trig_out;
    logic [CNT_W-1:0]       count;

    int n_chk  = 0;
    int n_fail = 0;
    int dly [N_CH] = '{0, 3, 7, 12, 5, 9, 20, 2};
    logic [N_CH-1:0] en_cfg  = 8'b1101_1111;
    logic [N_CH-1:0] byp_cfg = 8'b1001_0000;

    always #2.5 clk = ~clk;

    tdu_top #(.N_EXT(N_EXT), .SEL_W(SEL_W), .CNT_W(CNT_W), .N_GRP(N_GRP), .N_PRE(N_PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cont_mode(cont_mode), .dbg_halt(dbg_halt),
        .trig_sel(trig_sel), .ext_trig(ext_trig), .sw_trig(sw_trig), .modulus(modulus),
        .delay(delay), .pre_en(pre_en), .pre_byp(pre_byp), .pre_trig(pre_trig),
        .trig_out(trig_out), .count(count)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    function automatic bit exp_bit(int c, int eff, bit cont, bit blk_en);
        int e;
        if (!en_cfg[c]) return 1'b0;
        if (byp_cfg[c]) return eff == 1;
        if (!blk_en || eff < 2 || dly[c] > M) return 1'b0;
        e = eff - 2;
        return cont ? ((e % (M + 1)) == dly[c]) : (e == dly[c]);
    endfunction

    task automatic idle_reset();
        @(negedge clk);
        enable = 1'b0; sw_trig = 1'b0; ext_trig = '0; dbg_halt = 1'b0;
        repeat (5) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // Trigger at k=0, then compare pre_trig and trig_out each cycle (R2,R4,R5,R6,R7,R8,R9)
    task automatic run_window(input string rq, input bit use_ext, input int line,
                              input bit cont, input bit blk_en, input int ncyc);
        int off;
        logic [N_CH-1:0]  ep;
        logic [N_GRP-1:0] eg;
        @(negedge clk);
        cont_mode = cont;
        enable    = blk_en;
        if (use_ext) begin
            trig_sel = SEL_W'(line);
            ext_trig[line] = 1'b1;
            off = 2;
        end else begin
            trig_sel = SEL_W'(N_EXT);
            sw_trig  = 1'b1;
            off = 0;
        end
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            sw_trig = 1'b0;
            for (int c = 0; c < N_CH; c++) ep[c] = exp_bit(c, k - off, cont, blk_en);
            for (int g = 0; g < N_GRP; g++) eg[g] = |ep[g*N_PRE +: N_PRE];
            chk(pre_trig == ep, {rq, " pre_trig"}, 32'(pre_trig), 32'(ep));
            chk(trig_out == eg, "R9 trig_out", 32'(trig_out), 32'(eg));
        end
        if (!blk_en)
            chk(count == '0, "R1 count held at zero", 32'(count), 32'd0);
        else if (!cont)
            chk(count == CNT_W'(M), "R5 count stopped at modulus", 32'(count), 32'(M));
        ext_trig = '0;
    endtask

    task automatic t_reset();
        chk(pre_trig == '0, "R1 reset pre_trig", 32'(pre_trig), 32'd0);
        chk(trig_out == '0, "R9 reset trig_out", 32'(trig_out), 32'd0);
        chk(count == '0, "R1 reset count", 32'(count), 32'd0);
    endtask

    task automatic t_oneshot_sw();
        idle_reset();
        run_window("R4 R5 R7 R8 one-shot", 1'b0, 0, 1'b0, 1'b1, 2 * (M + 1) + 4);
    endtask

    task automatic t_continuous();
        idle_reset();
        run_window("R6 continuous", 1'b0, 0, 1'b1, 1'b1, 3 * (M + 1) + 4);
    endtask

    task automatic t_ext_held();
        idle_reset();
        run_window("R2 R3 external held", 1'b1, 2, 1'b0, 1'b1, 2 * (M + 1) + 6);
    endtask

    task automatic t_disabled();
        idle_reset();
        run_window("R1 R7 disabled", 1'b0, 0, 1'b0, 1'b0, M + 6);
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic t_unselected();
        idle_reset();
        cont_mode = 1'b0;
        trig_sel  = SEL_W'(1);
        ext_trig[2] = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(count == '0 && pre_trig == '0, "R2 unselected line ignored",
                32'({count, pre_trig}), 32'd0);
        end
        ext_trig = '0;
    endtask

    task automatic t_halt();
        int n2 = 0, n3 = 0, n4 = 0;
        idle_reset();
        cont_mode = 1'b0;
        trig_sel  = SEL_W'(N_EXT);
        sw_trig   = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            sw_trig = 1'b0;
            if (k == 4) chk(count == 16'd3, "R10 count before halt", 32'(count), 32'd3);
            if (k >= 5 && k <= 9) chk(count == 16'd3, "R10 count held", 32'(count), 32'd3);
            if (k == 10) chk(count == 16'd4, "R10 resume value", 32'(count), 32'd4);
            if (k == 11) chk(count == 16'd5, "R10 resume advance", 32'(count), 32'd5);
            if (pre_trig[2]) n2++;
            if (pre_trig[3]) n3++;
            if (pre_trig[4]) n4++;
            if (k == 4) dbg_halt = 1'b1;
            if (k == 6) sw_trig = 1'b1;
            if (k == 7) sw_trig = 1'b0;
            if (k == 9) dbg_halt = 1'b0;
        end
        chk(n2 == 1, "R10 delay-7 pulses once", 32'(n2), 32'd1);
        chk(n3 == 1, "R5 delay-M pulses once", 32'(n3), 32'd1);
        chk(n4 == 1, "R10 trigger ignored while halted", 32'(n4), 32'd1);
    endtask

    task automatic t_retrigger();
        int n4 = 0;
        idle_reset();
        cont_mode = 1'b0;
        trig_sel  = SEL_W'(N_EXT);
        sw_trig   = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            sw_trig = 1'b0;
            if (pre_trig[4]) n4++;
            if (k == 4) begin
                chk(count == 16'd3, "R11 count before retrigger", 32'(count), 32'd3);
                sw_trig = 1'b1;
            end
            if (k == 5) chk(count == 16'd0, "R11 restart at zero", 32'(count), 32'd0);
            if (k == 6) chk(count == 16'd1, "R11 count after restart", 32'(count), 32'd1);
        end
        chk(n4 == 2, "R7 bypass per event", 32'(n4), 32'd2);
    endtask

    initial begin
        #(5ns * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; cont_mode = 1'b0; dbg_halt = 1'b0;
        trig_sel = '0; ext_trig = '0; sw_trig = 1'b0;
        modulus = CNT_W'(M);
        for (int c = 0; c < N_CH; c++) delay[c*CNT_W +: CNT_W] = CNT_W'(dly[c]);
        pre_en = en_cfg; pre_byp = byp_cfg;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot_sw();
        t_continuous();
        t_ext_held();
        t_disabled();
        t_unselected();
        t_halt();
        t_retrigger();
        summary();
    end
endmodule